// File: doc/BRIEF.md
# I2C Register Target

This block connects a two-wire serial bus (I2C, standard and fast mode up to 400 kHz) to a bank of byte-wide registers. The two bus lines are brought in through synchronizers and sampled on a system clock of at least sixteen times the bus bit rate. The block recognises START and STOP conditions and answers at one fixed 7-bit address. It drives the data line only through a pull-down enable. An external open-drain pad turns that enable into a low level on the bus.

A write transaction carries the target address with the direction bit at 0, then one byte that loads an internal register pointer, then any number of data bytes. Each data byte is presented on the register bus as a one-cycle write strobe, and the pointer advances after each one. A read uses a repeated START with the direction bit at 1. Bytes are returned most significant bit first, starting at the current pointer, and the pointer advances after each byte. Every byte taken from a mapped register raises a one-cycle read strobe with that register's address, so that flag registers in the bank can clear when they are read. The number of mapped registers is a parameter. Pointer values outside that range read as zero and never strobe the bank.

Top module: `i2c_reg_target`

## Requirements
- R1: An address byte whose upper seven bits equal 1001000 binary is acknowledged on the ninth SCL pulse: SDA is held low for the whole high phase of that pulse. Each byte received after such an address is acknowledged the same way.
- R2: An address byte with any other value gets no acknowledge. Every later byte is then ignored, with no acknowledge and no register write, until the next START.
- R3: The block changes its SDA pull-down only while SCL is low. SDA stays constant through every SCL high phase of acknowledge and read-data bits.
- R4: In a write transaction (address LSB 0), the first byte after the address loads the register pointer. Each later byte produces one `regWrEn` pulse with `regAddr` equal to the pointer and `regWrData` equal to the byte, and the pointer then advances by one.
- R5: After a repeated START with address LSB 1, the block shifts out the register at the pointer, MSB first, one bit per SCL pulse. After each master acknowledge it returns the next register.
- R6: A master not-acknowledge after a read byte makes the block release SDA and go idle. No further read strobe follows until a new transaction.
- R7: Pointer values at or above NUM_REGS read back as 00h, whatever the bank returns, and writes to them produce no `regWrEn` pulse.
- R8: Each read byte taken from a mapped register raises `regRdStb` for exactly one cycle, with `regAddr` equal to that register's address. `regRdStb` and `regWrEn` never occur together.
- R9: A STOP or START in the middle of a byte drops the partial byte without any register write. A START then begins a new address phase.
- R10: After reset, SDA is released, no strobe is active and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the pad |
| sdaIn | input | 1 | Serial data line as seen on the pad |
| sdaPullLow | output | 1 | 1 pulls the SDA pad low; 0 releases it |
| regAddr | output | 8 | Register pointer presented to the bank |
| regWrData | output | 8 | Byte to be written |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdStb | output | 1 | One-cycle strobe when a mapped register is read |
| regRdData | input | 8 | Bank contents at `regAddr`, combinational |

## Verification
The assertions check on every cycle that the SDA pull-down never moves during an SCL high phase, that a STOP or START always releases SDA, and that the bit counter stays bounded. They also check that read and write strobes are exclusive and that each strobe advances the pointer by exactly one. They also tie entry into the address acknowledge to a matching address. Only the bench's scenarios can show that the correct data appears on the wire for each pointer, that unmapped addresses read as zero, and that a foreign address stays silent. The same goes for dropping an aborted byte, and for the pointer carrying over from a write into a repeated-START read.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgtState_t;

  // Events seen by the datapath, reported to the control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic byteDone;
    logic lastTxBit;
    logic addrHit;
    logic rwBit;
    logic sdaVal;
  } busEvt_t;

  // Strobes and levels from the control to the datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic clrCnt;
    logic loadRd;
    logic setPtr;
    logic wrReg;
    logic ackLow;
    logic txEn;
  } ctlStb_t;

endpackage

// File: rtl/i2c_tgt_dpath.sv
module i2c_tgt_dpath
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'b1001000,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  ctlStb_t    stb,
  output busEvt_t    evt,
  output logic       sdaPullLow,
  output logic [7:0] regAddr,
  output logic [7:0] regWrData,
  output logic       regWrEn,
  output logic       regRdStb,
  input  logic [7:0] regRdData
);

  localparam int          CNT_W     = 4;
  localparam logic [8:0]  MAP_LIMIT = 9'(NUM_REGS);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic                   sclS, sdaS, sclD, sdaD;
  logic [CNT_W-1:0]       bitCnt;
  logic [7:0]             rxByte, txByte, ptr;
  logic                   ptrMapped;

  // Input synchronizers, idle-high reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  assign ptrMapped = {1'b0, ptr} < MAP_LIMIT;

  always_comb begin
    evt.sclRise   = sclS & ~sclD;
    evt.sclFall   = ~sclS & sclD;
    evt.start     = sclS & sclD & sdaD & ~sdaS;
    evt.stop      = sclS & sclD & ~sdaD & sdaS;
    evt.byteDone  = (bitCnt == CNT_W'(8));
    evt.lastTxBit = (bitCnt == CNT_W'(7));
    evt.addrHit   = (rxByte[7:1] == TGT_ADDR);
    evt.rwBit     = rxByte[0];
    evt.sdaVal    = sdaS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
      txByte <= '0;
      ptr    <= '0;
    end else begin
      if (stb.clrCnt)                       bitCnt <= '0;
      else if (stb.shiftIn || stb.shiftOut) bitCnt <= bitCnt + CNT_W'(1);

      if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaS};

      if (stb.loadRd)        txByte <= ptrMapped ? regRdData : 8'h00;
      else if (stb.shiftOut) txByte <= {txByte[6:0], 1'b0};

      if (stb.setPtr)                   ptr <= rxByte;
      else if (stb.wrReg || stb.loadRd) ptr <= ptr + 8'd1;
    end
  end

  assign regAddr    = ptr;
  assign regWrData  = rxByte;
  assign regWrEn    = stb.wrReg & ptrMapped;
  assign regRdStb   = stb.loadRd & ptrMapped;
  assign sdaPullLow = stb.ackLow | (stb.txEn & ~txByte[7]);

  // R3: the pull-down holds across an SCL high phase
  p_sda_steady_scl_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS) && !$past(evt.start) && !$past(evt.stop)) |-> $stable(sdaPullLow));

  // R9: a STOP or START always frees the data line
  p_release_on_cond_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evt.stop || evt.start) |=> !sdaPullLow);

  // R9: bit counter never passes a full byte
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(8));

  // R8: strobes are exclusive
  p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, regRdStb}));

  // R8: a read strobe advances the pointer by one
  p_rd_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    regRdStb |=> regAddr == $past(regAddr) + 8'd1);

  // R4: a write strobe advances the pointer by one
  p_wr_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regAddr == $past(regAddr) + 8'd1);

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  busEvt_t evt,
  output ctlStb_t stb
);

  tgtState_t state, stateNext;
  logic      ptrPhase, ptrPhaseNext;
  logic      nackSeen, nackNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ptrPhase <= 1'b0;
      nackSeen <= 1'b0;
    end else begin
      state    <= stateNext;
      ptrPhase <= ptrPhaseNext;
      nackSeen <= nackNext;
    end
  end

  always_comb begin
    stateNext    = state;
    ptrPhaseNext = ptrPhase;
    nackNext     = nackSeen;
    stb          = '0;
    stb.ackLow   = (state == ST_ADDR_ACK) || (state == ST_WR_ACK);
    stb.txEn     = (state == ST_RD);

    if (evt.stop) begin
      stateNext  = ST_IDLE;
      stb.clrCnt = 1'b1;
    end else if (evt.start) begin
      stateNext  = ST_ADDR;
      stb.clrCnt = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (evt.sclRise && !evt.byteDone) begin
            stb.shiftIn = 1'b1;
          end else if (evt.sclFall && evt.byteDone) begin
            stb.clrCnt = 1'b1;
            stateNext  = evt.addrHit ? ST_ADDR_ACK : ST_IDLE;
          end
        end
        ST_ADDR_ACK: begin
          if (evt.sclFall) begin
            stb.clrCnt = 1'b1;
            if (evt.rwBit) begin
              stateNext  = ST_RD;
              stb.loadRd = 1'b1;
            end else begin
              stateNext    = ST_WR;
              ptrPhaseNext = 1'b1;
            end
          end
        end
        ST_WR: begin
          if (evt.sclRise && !evt.byteDone) begin
            stb.shiftIn = 1'b1;
          end else if (evt.sclFall && evt.byteDone) begin
            stb.clrCnt = 1'b1;
            stateNext  = ST_WR_ACK;
            if (ptrPhase) begin
              stb.setPtr   = 1'b1;
              ptrPhaseNext = 1'b0;
            end else begin
              stb.wrReg = 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (evt.sclFall) stateNext = ST_WR;
        end
        ST_RD: begin
          if (evt.sclFall) begin
            if (evt.lastTxBit) begin
              stateNext  = ST_RD_ACK;
              stb.clrCnt = 1'b1;
            end else begin
              stb.shiftOut = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (evt.sclRise) begin
            nackNext = evt.sdaVal;
          end else if (evt.sclFall) begin
            if (nackSeen) begin
              stateNext = ST_IDLE;
            end else begin
              stateNext  = ST_RD;
              stb.loadRd = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R1: the address acknowledge is entered only on a matching address byte
  p_ack_needs_hit_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> $past(evt.addrHit));

  // R6: leaving the read-acknowledge slot for idle needs a latched NACK or a bus condition
  p_nack_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_RD_ACK && state == ST_IDLE) |-> ($past(nackSeen) || $past(evt.stop)));

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'b1001000,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullLow,
  output logic [7:0] regAddr,
  output logic [7:0] regWrData,
  output logic       regWrEn,
  output logic       regRdStb,
  input  logic [7:0] regRdData
);

  busEvt_t evt;
  ctlStb_t stb;

  i2c_tgt_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .evt  (evt),
    .stb  (stb)
  );

  i2c_tgt_dpath #(
    .TGT_ADDR    (TGT_ADDR),
    .NUM_REGS    (NUM_REGS),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .stb        (stb),
    .evt        (evt),
    .sdaPullLow (sdaPullLow),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regWrEn    (regWrEn),
    .regRdStb   (regRdStb),
    .regRdData  (regRdData)
  );

endmodule

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;

  localparam int         Q      = 5;
  localparam logic [7:0] ADDR_W = 8'h90;
  localparam logic [7:0] ADDR_R = 8'h91;

  // Vector table: {pointer, data}; write one byte, then read it back
  localparam logic [15:0] VEC [0:7] = '{
    16'h00_3C, 16'h0F_C3, 16'h07_FF, 16'h08_00,
    16'h14_5A, 16'hFF_11, 16'h03_81, 16'h0A_E7
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       sdaBus;
  logic       sdaPullLow, regWrEn, regRdStb;
  logic [7:0] regAddr, regWrData, regRdData;

  logic [7:0] bank  [0:15];
  logic [7:0] model [0:15];
  logic [7:0] rdLog [0:255];
  int         rdCount = 0;
  int         wrCount = 0;
  int         checks = 0;
  int         fails = 0;

  always #4 clk = ~clk;

  assign sdaBus    = sdaM & ~sdaPullLow;
  assign regRdData = (regAddr < 8'd16) ? bank[regAddr[3:0]] : 8'hA5;

  i2c_reg_target dut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaBus),
    .sdaPullLow (sdaPullLow),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regWrEn    (regWrEn),
    .regRdStb   (regRdStb),
    .regRdData  (regRdData)
  );

  initial begin
    for (int i = 0; i < 16; i++) begin
      bank[i]  = 8'h00;
      model[i] = 8'h00;
    end
  end

  always @(posedge clk) begin
    if (regWrEn) begin
      bank[regAddr[3:0]] <= regWrData;
      wrCount <= wrCount + 1;
    end
    if (regRdStb) begin
      rdLog[rdCount[7:0]] <= regAddr;
      rdCount <= rdCount + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] expOf(input logic [7:0] a);
    return (a < 8'd16) ? model[a[3:0]] : 8'h00;
  endfunction

  task automatic startCond();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b;    tick(Q);
    sclM = 1'b1; tick(2*Q);
    sclM = 1'b0; tick(Q);
  endtask

  // acked=1 only if SDA is low on every sample of the ninth high phase
  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1;
    acked = 1'b1;
    repeat (2*Q) begin
      tick(1);
      if (sdaBus !== 1'b0) acked = 1'b0;
    end
    sclM = 1'b0; tick(Q);
  endtask

  task automatic readByte(input logic nack, output logic [7:0] d, output logic steady);
    logic bitv;
    sdaM = 1'b1;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      sclM = 1'b1;
      tick(1);
      bitv = sdaBus;
      d[i] = bitv;
      repeat (2*Q-1) begin
        tick(1);
        if (sdaBus !== bitv) steady = 1'b0;
      end
      sclM = 1'b0;
    end
    sdaM = nack; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sclM = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  task automatic writeBurst(input logic [7:0] ptr, input int n,
                            input logic [7:0] first, input logic [7:0] step);
    logic ack;
    logic [7:0] a, d;
    startCond();
    sendByte(ADDR_W, ack); check("R1 write address ack", ack, 1);
    sendByte(ptr, ack);    check("R1 pointer byte ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      a = ptr + 8'(i);
      d = first + 8'(i) * step;
      sendByte(d, ack);
      check("R4 data byte ack", ack, 1);
      if (a < 8'd16) model[a[3:0]] = d;
    end
    stopCond();
  endtask

  task automatic readBurst(input logic [7:0] ptr, input int n);
    logic ack, steady;
    logic [7:0] d;
    startCond();
    sendByte(ADDR_W, ack); check("R1 address ack before read", ack, 1);
    sendByte(ptr, ack);    check("R1 pointer ack before read", ack, 1);
    startCond();
    sendByte(ADDR_R, ack); check("R5 read address ack after repeated START", ack, 1);
    for (int i = 0; i < n; i++) begin
      readByte(i == n - 1, d, steady);
      check((ptr + 8'(i) < 8'd16) ? "R5 read data" : "R7 unmapped reads zero",
            d, expOf(ptr + 8'(i)));
      check("R3 SDA steady while SCL high", steady, 1);
    end
    tick(2);
    check("R6 SDA released after NACK", sdaPullLow, 0);
    stopCond();
  endtask

  initial begin
    int  wr0, rd0;
    logic ack;
    tick(3);
    rstN = 1'b1;
    tick(2);
    check("R10 reset SDA released", sdaPullLow, 0);
    check("R10 reset no write strobe", regWrEn, 0);
    check("R10 reset no read strobe", regRdStb, 0);
    check("R10 reset pointer zero", regAddr, 0);
    tick(4*Q);

    // Vector table walk
    for (int v = 0; v < 8; v++) begin
      writeBurst(VEC[v][15:8], 1, VEC[v][7:0], 8'h00);
      readBurst(VEC[v][15:8], 1);
      tick(2*Q);
    end

    // R4/R5/R8: burst write, burst read with auto-increment and strobe log
    writeBurst(8'h04, 3, 8'h10, 8'h11);
    check("R4 bank holds burst byte", bank[5], 8'h21);
    rd0 = rdCount;
    readBurst(8'h04, 3);
    tick(Q);
    check("R8 read strobe count", rdCount - rd0, 3);
    check("R6 no extra strobe after NACK", rdCount - rd0, 3);
    for (int i = 0; i < 3; i++)
      check("R8 strobe address", rdLog[8'(rd0 + i)], 4 + i);

    // R2: foreign address is ignored
    wr0 = wrCount;
    startCond();
    sendByte(8'h92, ack); check("R2 no ack for foreign address", ack, 0);
    sendByte(8'h02, ack); check("R2 no ack for later byte", ack, 0);
    sendByte(8'h77, ack); check("R2 no ack for data byte", ack, 0);
    stopCond();
    check("R2 no write after foreign address", wrCount - wr0, 0);

    // R7: unmapped writes and reads
    wr0 = wrCount;
    rd0 = rdCount;
    writeBurst(8'h30, 2, 8'h44, 8'h01);
    check("R7 no write strobe when unmapped", wrCount - wr0, 0);
    readBurst(8'h30, 2);
    check("R7 no read strobe when unmapped", rdCount - rd0, 0);

    // R9: STOP in the middle of a data byte
    writeBurst(8'h02, 1, 8'h66, 8'h00);
    wr0 = wrCount;
    startCond();
    sendByte(ADDR_W, ack);
    sendByte(8'h02, ack);
    for (int i = 0; i < 4; i++) sendBit(i[0]);
    stopCond();
    check("R9 STOP mid-byte writes nothing", wrCount - wr0, 0);
    readBurst(8'h02, 1);

    // R9: START in the middle of a byte restarts the address phase
    wr0 = wrCount;
    startCond();
    sendByte(ADDR_W, ack);
    sendByte(8'h02, ack);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    startCond();
    check("R9 START mid-byte writes nothing", wrCount - wr0, 0);
    sendByte(ADDR_W, ack); check("R9 fresh address phase acked", ack, 1);
    sendByte(8'h02, ack);
    sendByte(8'h99, ack);
    stopCond();
    model[2] = 8'h99;
    readBurst(8'h02, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule